// File: doc/BRIEF.md
# Variable-Latency Five-Stage Pipeline Controller

This block is a cycle-accurate timing model of an in-order instruction pipeline with five stages: fetch, decode, operand fetch, execute and writeback. It moves instruction tokens between stage registers. Each token carries an identifier, a two-bit execute-latency field and an end-of-program marker. Fetch, decode, operand fetch and writeback each hold a token for exactly one cycle. The execute stage keeps a token for as many cycles as its latency field asks. While execute is busy, the three earlier stages freeze and writeback receives a bubble.

A producer presents tokens on the input side. A token is taken on a clock edge when `in_valid` and `in_ready` are both high. The block counts elapsed cycles from the first fetch and counts retired tokens. It raises `done` when the marked last token leaves writeback. Real decoding, register files, hazard detection and branching are not modelled. The model assumes a stream with no data or control dependences.

Top module: `pipe5_vlat`

## Requirements
- R1: A token with latency 1, accepted into an empty pipeline, occupies fetch in cycle 1 and is presented on `ret_valid`/`ret_id` in cycle 5.
- R2: The `in_lat` field gives the number of execute cycles: 1, 2 or 3. The value 0 behaves as 1.
- R3: While the execute stage holds a token with more than one cycle remaining, `in_ready` is low, and fetch, decode and operand fetch keep their contents.
- R4: Writeback receives a bubble on every cycle the execute stage is still busy, so `ret_valid` is low in the cycle after any cycle with `in_ready` low.
- R5: Tokens retire in acceptance order, at most one per cycle. Token i of a back-to-back stream retires in cycle 4 plus the sum of the effective latencies of tokens 0..i.
- R6: `cycle_count` counts every cycle from the first fetch through the cycle in which the last token is in writeback. A back-to-back stream of 40 latency-3, 35 latency-2 and 25 latency-1 tokens ends at 219.
- R7: `retired_count` increases by exactly one in each cycle after `ret_valid` is high, and by nothing otherwise.
- R8: `done` rises after the token accepted with `in_last` high leaves writeback. From then on `done` stays high and `cycle_count` stays frozen.
- R9: Synchronous active-high `rst` empties every stage and clears the latency counter and both counters. After reset, `in_ready` is 1 and `ret_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a token |
| in_id | input | ID_W | Token identifier |
| in_lat | input | LAT_W | Execute-stage latency (0 treated as 1) |
| in_last | input | 1 | Marks the final token of the program |
| in_ready | output | 1 | Fetch can take a token this cycle |
| ret_valid | output | 1 | A token is in writeback |
| ret_id | output | ID_W | Identifier of the token in writeback |
| cycle_count | output | CNT_W | Cycles elapsed since the first fetch |
| retired_count | output | CNT_W | Tokens that have passed writeback |
| done | output | 1 | Last token has left writeback |

## Verification
The bench builds the block with an 8-bit identifier, the default 2-bit latency field and a 12-bit counter width. The 8-bit identifier gives all 100 tokens of the long mixed run distinct IDs, so any reordering or duplication shows up at the retire port. The 2-bit latency field lets the bench apply the out-of-range value 0. The 12-bit counters hold the 219-cycle total with margin, so an off-by-one in the fill or drain count shows up as a value mismatch rather than being hidden by wrap-around.

// File: rtl/p5_pkg.sv
package p5_pkg;
  // number of single-cycle stages ahead of the execute stage
  localparam int FRONT_STAGES = 3;
  // cycles spent outside execute by a token passing alone
  localparam int FILL_CYCLES  = 4;
endpackage

// File: rtl/p5_stage_reg.sv
module p5_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_d <= '0;
    end else if (en) begin
      out_v <= in_v;
      out_d <= in_d;
    end
  end
endmodule

// File: rtl/p5_exec_stage.sv
module p5_exec_stage #(
  parameter int W       = 11,
  parameter int LAT_W   = 2,
  parameter int LAT_LSB = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         busy,
  output logic         fin_v,
  output logic [W-1:0] fin_d
);
  logic             ex_v;
  logic [W-1:0]     ex_d;
  logic [LAT_W-1:0] remain;

  // more than one cycle left: hold everything upstream
  assign busy  = ex_v && (remain > LAT_W'(1));
  assign fin_v = ex_v && !busy;
  assign fin_d = ex_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_v   <= 1'b0;
      ex_d   <= '0;
      remain <= '0;
    end else if (busy) begin
      remain <= remain - LAT_W'(1);
    end else begin
      ex_v   <= in_v;
      ex_d   <= in_d;
      remain <= in_d[LAT_LSB +: LAT_W];
    end
  end
endmodule

// File: rtl/p5_perf_ctr.sv
module p5_perf_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_v,
  input  logic             wb_v,
  input  logic             wb_last,
  output logic [CNT_W-1:0] cycles,
  output logic [CNT_W-1:0] retired,
  output logic             fin
);
  logic started;
  logic running;

  assign running = (started || fetch_v) && !fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      cycles  <= '0;
      retired <= '0;
      fin     <= 1'b0;
    end else begin
      if (fetch_v) started <= 1'b1;
      if (running) cycles <= cycles + CNT_W'(1);
      if (wb_v) retired <= retired + CNT_W'(1);
      if (wb_v && wb_last) fin <= 1'b1;
    end
  end
endmodule

// File: rtl/pipe5_vlat.sv
module pipe5_vlat #(
  parameter int ID_W  = 8,
  parameter int LAT_W = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [ID_W-1:0]  in_id,
  input  logic [LAT_W-1:0] in_lat,
  input  logic             in_last,
  output logic             in_ready,
  output logic             ret_valid,
  output logic [ID_W-1:0]  ret_id,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] retired_count,
  output logic             done
);
  localparam int NF      = p5_pkg::FRONT_STAGES;
  localparam int TOK_W   = ID_W + LAT_W + 1;
  localparam int LAT_LSB = ID_W;
  localparam int LAST_B  = TOK_W - 1;

  logic             fv [0:NF];
  logic [TOK_W-1:0] fd [0:NF];
  logic             stall;
  logic             x_v;
  logic [TOK_W-1:0] x_d;
  logic             wb_v;
  logic [TOK_W-1:0] wb_d;

  assign fv[0] = in_valid;
  assign fd[0] = {in_last, in_lat, in_id};

  for (genvar g = 0; g < NF; g++) begin : g_front
    p5_stage_reg #(.W(TOK_W)) u_st (
      .clk  (clk),
      .rst  (rst),
      .en   (!stall),
      .in_v (fv[g]),
      .in_d (fd[g]),
      .out_v(fv[g+1]),
      .out_d(fd[g+1])
    );
  end

  p5_exec_stage #(.W(TOK_W), .LAT_W(LAT_W), .LAT_LSB(LAT_LSB)) u_exec (
    .clk  (clk),
    .rst  (rst),
    .in_v (fv[NF]),
    .in_d (fd[NF]),
    .busy (stall),
    .fin_v(x_v),
    .fin_d(x_d)
  );

  p5_stage_reg #(.W(TOK_W)) u_wb (
    .clk  (clk),
    .rst  (rst),
    .en   (1'b1),
    .in_v (x_v),
    .in_d (x_d),
    .out_v(wb_v),
    .out_d(wb_d)
  );

  p5_perf_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .fetch_v(fv[1]),
    .wb_v   (wb_v),
    .wb_last(wb_d[LAST_B]),
    .cycles (cycle_count),
    .retired(retired_count),
    .fin    (done)
  );

  assign in_ready  = !stall;
  assign ret_valid = wb_v;
  assign ret_id    = wb_d[ID_W-1:0];
endmodule

// File: rtl/p5_chk.sv
module p5_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             ret_valid,
  input logic [CNT_W-1:0] cycle_count,
  input logic [CNT_W-1:0] retired_count,
  input logic             done
);
  // R4: a stalled cycle sends a bubble into writeback
  p_bubble_r4: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !ret_valid);

  // R2, R3: latency at most 3, so no more than two stalled cycles in a row
  p_stall_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && $past(!in_ready)) |=> in_ready);

  // R7: retired count steps with the retire strobe
  p_retire_step_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (retired_count == $past(retired_count) + CNT_W'($past(ret_valid))));

  // R8: done is sticky and freezes the cycle count
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(cycle_count)));

  // R9: state right after reset is released
  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !ret_valid && !done && cycle_count == '0 && retired_count == '0));
endmodule

bind pipe5_vlat p5_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_ready     (in_ready),
  .ret_valid    (ret_valid),
  .cycle_count  (cycle_count),
  .retired_count(retired_count),
  .done         (done)
);

// File: tb/pipe5_vlat_tb.sv
module pipe5_vlat_tb;
  localparam int ID_W  = 8;
  localparam int LAT_W = 2;
  localparam int CNT_W = 12;
  localparam int NTAB  = 8;
  localparam int MAXN  = 128;

  // table rows: {id, lat}
  localparam logic [ID_W+LAT_W-1:0] TAB [0:NTAB-1] = '{
    {8'h10, 2'd1}, {8'h21, 2'd3}, {8'h32, 2'd2}, {8'h43, 2'd0},
    {8'h54, 2'd3}, {8'h65, 2'd1}, {8'h76, 2'd1}, {8'h87, 2'd2}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [ID_W-1:0]  in_id = '0;
  logic [LAT_W-1:0] in_lat = '0;
  logic             in_last = 1'b0;
  logic             in_ready, ret_valid, done;
  logic [ID_W-1:0]  ret_id;
  logic [CNT_W-1:0] cycle_count, retired_count;

  int tests = 0;
  int fails = 0;
  int exp_id  [0:MAXN-1];
  int exp_cyc [0:MAXN-1];
  int npush = 0;
  int ridx = 0;
  int cum = 0;
  int tcyc = 0;
  int stall_seen = 0;
  bit tb_run = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pipe5_vlat #(.ID_W(ID_W), .LAT_W(LAT_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_id(in_id), .in_lat(in_lat),
    .in_last(in_last), .in_ready(in_ready), .ret_valid(ret_valid), .ret_id(ret_id),
    .cycle_count(cycle_count), .retired_count(retired_count), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (tb_run) tcyc++;

  // retire monitor: order (R5) and exact retire cycle (R1, R5)
  always @(negedge clk) begin
    if (tb_run && !rst && !done && !in_ready) stall_seen++;
    if (tb_run && !rst && ret_valid) begin
      if (ridx < npush) begin
        check(int'(ret_id) == exp_id[ridx], "R5 order", int'(ret_id), exp_id[ridx]);
        check(tcyc == exp_cyc[ridx], "R1/R5 retire cycle", tcyc, exp_cyc[ridx]);
      end else begin
        check(1'b0, "R5 extra retire", ridx, npush);
      end
      ridx++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    tb_run = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    npush = 0; ridx = 0; cum = 0; tcyc = 0; stall_seen = 0;
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic push(input int id, input int lat, input bit last);
    bit r;
    if (!tb_run) begin
      tb_run = 1'b1;
      tcyc = 0;
    end
    exp_id[npush] = id;
    cum += (lat == 0) ? 1 : lat;
    exp_cyc[npush] = p5_pkg::FILL_CYCLES + cum;
    npush++;
    in_valid = 1'b1;
    in_id = ID_W'(id);
    in_lat = LAT_W'(lat);
    in_last = last;
    forever begin
      r = in_ready;
      @(posedge clk);
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 1000 && !done; k++) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    check(in_ready == 1'b1, {tag, " in_ready"}, int'(in_ready), 1);
    check(ret_valid == 1'b0, {tag, " ret_valid"}, int'(ret_valid), 0);
    check(done == 1'b0, {tag, " done"}, int'(done), 0);
    check(cycle_count == '0, {tag, " cycle_count"}, int'(cycle_count), 0);
    check(retired_count == '0, {tag, " retired_count"}, int'(retired_count), 0);
  endtask

  initial begin
    int frozen, nstall;
    // R9: state after power-on reset
    do_reset();
    check_reset_state("R9 initial");

    // R1: lone latency-1 token retires in cycle 5, count ends at 5
    push(8'h05, 1, 1'b1);
    wait_done();
    check(int'(cycle_count) == 5, "R1 lone token cycles", int'(cycle_count), 5);
    check(ridx == 1, "R1 lone token retired", ridx, 1);

    // table walk: mixed latencies incl. 0 treated as 1 (R2)
    do_reset();
    for (int i = 0; i < NTAB; i++)
      push(int'(TAB[i][ID_W+LAT_W-1:LAT_W]), int'(TAB[i][LAT_W-1:0]), i == NTAB-1);
    wait_done();
    check(int'(cycle_count) == p5_pkg::FILL_CYCLES + cum, "R2/R6 table cycles",
          int'(cycle_count), p5_pkg::FILL_CYCLES + cum);
    check(int'(retired_count) == NTAB, "R7 table retired", int'(retired_count), NTAB);
    check(stall_seen == cum - NTAB, "R3 table stall cycles", stall_seen, cum - NTAB);
    frozen = int'(cycle_count);
    repeat (5) @(negedge clk);
    check(int'(cycle_count) == frozen, "R8 count frozen", int'(cycle_count), frozen);
    check(done == 1'b1, "R8 done sticky", int'(done), 1);

    // long run: 40 x 3, 35 x 2, 25 x 1 interleaved
    do_reset();
    for (int i = 0; i < 100; i++) begin
      int m, l;
      m = i % 20;
      l = (m < 8) ? 3 : (m < 15) ? 2 : 1;
      push(i, l, i == 99);
    end
    wait_done();
    check(int'(cycle_count) == 219, "R6 mix cycles", int'(cycle_count), 219);
    check(int'(retired_count) == 100, "R7 mix retired", int'(retired_count), 100);
    check(ridx == 100, "R5 mix retire events", ridx, 100);
    check(stall_seen == 115, "R3 mix stall cycles", stall_seen, 115);

    // R9: reset while busy with latency-3 tokens
    do_reset();
    push(8'hA0, 3, 1'b0);
    push(8'hA1, 3, 1'b0);
    push(8'hA2, 3, 1'b1);
    do_reset();
    check_reset_state("R9 mid-stream");
    nstall = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (ret_valid || !in_ready) nstall++;
    end
    check(nstall == 0, "R9 pipeline emptied", nstall, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule